// File: doc/BRIEF.md
# Three-Phase Center-Aligned PWM Generator

This block produces the six gate-drive signals of a three-phase voltage-source inverter. There is one high-side and one low-side signal for each of the phases A, B and C. A 16-bit counter counts up and then back down, so every PWM period is symmetric about its midpoint. Each phase compares the counter against its own duty value. Dead time is added by delaying the turn-on edge of each signal, and pulses too narrow for the power stage are dropped.

Software programs the block through a single-cycle write port. The period, dead time, minimum pulse width and the three duty values are held in shadow registers and take effect at defined reload points. The per-output enables, the per-phase swap bits, the chopping carrier and the update mode act at once. For pulse-transformer gate drives, a carrier can be mixed into the high-side or low-side group. An active-low trip pin turns every output off without waiting for a clock edge and latches a fault. A one-cycle pulse marks the start of each period.

Top module: `pwm3_gen`

## Requirements
- R1: The period register (address 0, value P, where 0 counts as 1) sets a period of exactly 2P clock cycles. A period's cycles are numbered k = 0 … 2P−1, and the counter value is c = k in the first half and c = 2P−1−k in the second half. `sync_irq` is high for one cycle, in cycle k = 0 of every period. After reset the period register holds 100.
- R2: For a phase with duty D (addresses 3, 4 and 5 for A, B and C; D above P is treated as P) and dead time 0, the high side is on while c ≥ P−D. This gives 2D high cycles and 2(P−D) low cycles per period.
- R3: Let the dead time (address 1) be T. In the first half, the high side is on while c ≥ P−D+T and the low side while c < P−D. In the second half, the high side is on while c ≥ P−D and the low side while c+T < P−D. The high and low outputs of a pair are never on together.
- R4: Let the minimum pulse width (address 2) be W. A high-side pulse whose width 2D−T is less than W is suppressed, and so is a low-side pulse whose width 2(P−D)−T is less than W. A suppressed output stays off.
- R5: With mode bit 0 (address 9) clear, a duty write takes effect only at the next period start. The period, dead time and minimum width are loaded only at a period start.
- R6: With mode bit 0 set, the duty values are also loaded at the midpoint. A write made in the first half therefore changes the second half of the same period.
- R7: Address 6 holds the output enables. Bits 2:0 enable the high outputs of A, B and C, and bits 5:3 enable the low outputs. A disabled output is driven 0.
- R8: Address 7 bits 2:0 swap phases A, B and C. When a phase's bit is set, its high-side waveform appears on the low pin and its low-side waveform on the high pin.
- R9: Address 8 holds the chopping setup: bits 7:0 are a divider N, bit 8 chops the high pins and bit 9 chops the low pins. A chopped pin is on only while the carrier is high. The carrier is high in cycle k exactly when floor(k/(N+1)) is even.
- R10: A low on `trip_n` forces all six outputs to 0 at once. It also sets `trip_irq` within three clock cycles. The fault stays latched, with the outputs off, after `trip_n` returns high.
- R11: Writing 1 to bit 0 at address 10 clears the latched fault only while the synchronized trip input is high. A clear written while the trip is still low has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write data |
| trip_n | input | 1 | Active-low asynchronous trip |
| pwm_hi | output | 3 | High-side drives for A, B, C |
| pwm_lo | output | 3 | Low-side drives for A, B, C |
| sync_irq | output | 1 | One-cycle period-start pulse |
| trip_irq | output | 1 | Latched trip fault |

## Verification
The hardest case to reach is a period whose two halves use different duty values. It only occurs when a duty write lands after a period starts and before its midpoint, and only in double-update mode. The stimulus waits for the sync pulse and writes the new duty on the next cycle. It then predicts an asymmetric period in double mode and an unchanged one in single mode. A second hard case is a clear issued while the trip pin is still low. The stimulus holds the pin low past the synchronizer, writes the clear, and only then releases the pin.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;

  typedef enum logic [3:0] {
    A_PERIOD  = 4'd0,
    A_DEAD    = 4'd1,
    A_MINPW   = 4'd2,
    A_DUTY_A  = 4'd3,
    A_DUTY_B  = 4'd4,
    A_DUTY_C  = 4'd5,
    A_OUTEN   = 4'd6,
    A_SWAP    = 4'd7,
    A_CHOP    = 4'd8,
    A_MODE    = 4'd9,
    A_TRIPCLR = 4'd10
  } reg_addr_e;

  localparam int NPH = 3;

endpackage

// File: rtl/pwm3_regs.sv
module pwm3_regs
  import pwm3_pkg::*;
#(
  parameter int CW         = 16,
  parameter int CHW        = 8,
  parameter int RST_PERIOD = 100
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [3:0]              wr_addr,
  input  logic [CW-1:0]           wr_data,
  output logic [CW-1:0]           per_sh,
  output logic [CW-1:0]           dt_sh,
  output logic [CW-1:0]           mpw_sh,
  output logic [NPH-1:0][CW-1:0]  duty_sh,
  output logic [2*NPH-1:0]        en,
  output logic [NPH-1:0]          swap,
  output logic [CHW-1:0]          chop_div,
  output logic                    chop_hi,
  output logic                    chop_lo,
  output logic                    dbl,
  output logic                    trip_clr
);

  always_ff @(posedge clk) begin
    if (rst) begin
      per_sh   <= CW'(RST_PERIOD);
      dt_sh    <= '0;
      mpw_sh   <= '0;
      en       <= '0;
      swap     <= '0;
      chop_div <= '0;
      chop_hi  <= 1'b0;
      chop_lo  <= 1'b0;
      dbl      <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        A_PERIOD: per_sh <= wr_data;
        A_DEAD:   dt_sh  <= wr_data;
        A_MINPW:  mpw_sh <= wr_data;
        A_OUTEN:  en     <= wr_data[2*NPH-1:0];
        A_SWAP:   swap   <= wr_data[NPH-1:0];
        A_CHOP: begin
          chop_div <= wr_data[CHW-1:0];
          chop_hi  <= wr_data[CHW];
          chop_lo  <= wr_data[CHW+1];
        end
        A_MODE:   dbl    <= wr_data[0];
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NPH; g++) begin : g_duty
    always_ff @(posedge clk) begin
      if (rst) duty_sh[g] <= '0;
      else if (wr_en && (wr_addr == 4'(int'(A_DUTY_A) + g))) duty_sh[g] <= wr_data;
    end
  end

  assign trip_clr = wr_en && (wr_addr == A_TRIPCLR) && wr_data[0];

endmodule

// File: rtl/pwm3_timebase.sv
module pwm3_timebase #(
  parameter int CW  = 16,
  parameter int CHW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [CW-1:0]  per_sh,
  input  logic [CW-1:0]  dt_sh,
  input  logic [CW-1:0]  mpw_sh,
  input  logic [CHW-1:0] chop_div,
  output logic [CW-1:0]  ctr,
  output logic           up,
  output logic [CW-1:0]  pact,
  output logic [CW-1:0]  dt_act,
  output logic [CW-1:0]  mpw_act,
  output logic           start_evt,
  output logic           mid_evt,
  output logic           first_cyc,
  output logic           carrier
);

  localparam logic [CW-1:0]  ONE  = CW'(1);
  localparam logic [CHW-1:0] ONEC = CHW'(1);

  logic [CHW-1:0] chop_cnt;

  assign start_evt = !up && (ctr == '0);
  assign mid_evt   = up && (ctr == pact - ONE);
  assign first_cyc = up && (ctr == '0);

  // Triangle counter: 0 .. P-1 rising, then P-1 .. 0 falling.
  always_ff @(posedge clk) begin
    if (rst) begin
      ctr     <= '0;
      up      <= 1'b0;
      pact    <= ONE;
      dt_act  <= '0;
      mpw_act <= '0;
    end else if (start_evt) begin
      up      <= 1'b1;
      pact    <= (per_sh == '0) ? ONE : per_sh;
      dt_act  <= dt_sh;
      mpw_act <= mpw_sh;
    end else if (mid_evt) begin
      up <= 1'b0;
    end else if (up) begin
      ctr <= ctr + ONE;
    end else begin
      ctr <= ctr - ONE;
    end
  end

  // Chopping carrier, phase-locked to the period start.
  always_ff @(posedge clk) begin
    if (rst) begin
      chop_cnt <= '0;
      carrier  <= 1'b1;
    end else if (start_evt) begin
      chop_cnt <= '0;
      carrier  <= 1'b1;
    end else if (chop_cnt == chop_div) begin
      chop_cnt <= '0;
      carrier  <= ~carrier;
    end else begin
      chop_cnt <= chop_cnt + ONEC;
    end
  end

  p_ctr_range_r1: assert property (@(posedge clk) disable iff (rst)
    ctr < pact);

  p_sync_single_r1: assert property (@(posedge clk) disable iff (rst)
    start_evt |=> !start_evt);

  p_mid_turn_r6: assert property (@(posedge clk) disable iff (rst)
    mid_evt |=> (!up && ctr == $past(ctr)));

endmodule

// File: rtl/pwm3_phase.sv
module pwm3_phase #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] duty_sh,
  input  logic          load,
  input  logic [CW-1:0] ctr,
  input  logic          up,
  input  logic [CW-1:0] pact,
  input  logic [CW-1:0] dt,
  input  logic [CW-1:0] mpw,
  output logic          hi,
  output logic          lo
);

  localparam int XW = CW + 3;

  logic [CW-1:0] dact, d;
  logic [XW-1:0] cx, tx, dtx, mpx, d2, t2;
  logic          hi_raw, lo_raw, kill_hi, kill_lo;

  always_ff @(posedge clk) begin
    if (rst)       dact <= '0;
    else if (load) dact <= duty_sh;
  end

  always_comb begin
    d   = (dact > pact) ? pact : dact;
    cx  = XW'(ctr);
    tx  = XW'(pact) - XW'(d);
    dtx = XW'(dt);
    mpx = XW'(mpw);
    d2  = XW'(d) << 1;
    t2  = tx << 1;
    kill_hi = $signed(d2 - dtx) < $signed(mpx);
    kill_lo = $signed(t2 - dtx) < $signed(mpx);
    if (up) begin
      hi_raw = cx >= (tx + dtx);
      lo_raw = cx < tx;
    end else begin
      hi_raw = cx >= tx;
      lo_raw = (cx + dtx) < tx;
    end
    hi = hi_raw & ~kill_hi;
    lo = lo_raw & ~kill_lo;
  end

  p_pair_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(hi && lo));

endmodule

// File: rtl/pwm3_trip.sv
module pwm3_trip (
  input  logic clk,
  input  logic rst,
  input  logic trip_n,
  input  logic clr,
  output logic trip_lat,
  output logic off
);

  logic s1, s2;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1       <= 1'b1;
      s2       <= 1'b1;
      trip_lat <= 1'b0;
    end else begin
      s1 <= trip_n;
      s2 <= s1;
      if (!s2)      trip_lat <= 1'b1;
      else if (clr) trip_lat <= 1'b0;
    end
  end

  // Raw pin gates the drives with no clock in the path.
  assign off = trip_lat | ~trip_n;

  p_trip_set_r10: assert property (@(posedge clk) disable iff (rst)
    !s2 |=> trip_lat);

  p_clear_blocked_r11: assert property (@(posedge clk) disable iff (rst)
    (trip_lat && !s2) |=> trip_lat);

endmodule

// File: rtl/pwm3_gen.sv
module pwm3_gen
  import pwm3_pkg::*;
#(
  parameter int CW         = 16,
  parameter int CHW        = 8,
  parameter int RST_PERIOD = 100
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [3:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic          trip_n,
  output logic [2:0]    pwm_hi,
  output logic [2:0]    pwm_lo,
  output logic          sync_irq,
  output logic          trip_irq
);

  logic [CW-1:0]          per_sh, dt_sh, mpw_sh, ctr, pact, dt_act, mpw_act;
  logic [NPH-1:0][CW-1:0] duty_sh;
  logic [2*NPH-1:0]       en;
  logic [NPH-1:0]         swap, ph_hi, ph_lo, mix_hi, mix_lo, hi_q, lo_q;
  logic [CHW-1:0]         chop_div;
  logic chop_hi, chop_lo, dbl, trip_clr, up, start_evt, mid_evt, first_cyc;
  logic carrier, duty_load, trip_lat, off, sync_q;

  pwm3_regs #(.CW(CW), .CHW(CHW), .RST_PERIOD(RST_PERIOD)) u_regs (
    .clk, .rst, .wr_en, .wr_addr, .wr_data,
    .per_sh, .dt_sh, .mpw_sh, .duty_sh, .en, .swap,
    .chop_div, .chop_hi, .chop_lo, .dbl, .trip_clr
  );

  pwm3_timebase #(.CW(CW), .CHW(CHW)) u_tb (
    .clk, .rst, .per_sh, .dt_sh, .mpw_sh, .chop_div,
    .ctr, .up, .pact, .dt_act, .mpw_act,
    .start_evt, .mid_evt, .first_cyc, .carrier
  );

  assign duty_load = start_evt | (mid_evt & dbl);

  for (genvar g = 0; g < NPH; g++) begin : g_phase
    pwm3_phase #(.CW(CW)) u_ph (
      .clk, .rst, .duty_sh(duty_sh[g]), .load(duty_load),
      .ctr, .up, .pact, .dt(dt_act), .mpw(mpw_act),
      .hi(ph_hi[g]), .lo(ph_lo[g])
    );

    logic sw_hi, sw_lo;
    assign sw_hi     = swap[g] ? ph_lo[g] : ph_hi[g];
    assign sw_lo     = swap[g] ? ph_hi[g] : ph_lo[g];
    assign mix_hi[g] = sw_hi & (carrier | ~chop_hi) & en[g];
    assign mix_lo[g] = sw_lo & (carrier | ~chop_lo) & en[NPH+g];
  end

  pwm3_trip u_trip (
    .clk, .rst, .trip_n, .clr(trip_clr), .trip_lat, .off
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q   <= '0;
      lo_q   <= '0;
      sync_q <= 1'b0;
    end else begin
      hi_q   <= mix_hi;
      lo_q   <= mix_lo;
      sync_q <= first_cyc;
    end
  end

  assign pwm_hi   = hi_q & {NPH{~off}};
  assign pwm_lo   = lo_q & {NPH{~off}};
  assign sync_irq = sync_q;
  assign trip_irq = trip_lat;

  p_no_overlap_r3: assert property (@(posedge clk) disable iff (rst)
    (pwm_hi & pwm_lo) == '0);

  p_disabled_low_r7: assert property (@(posedge clk) disable iff (rst)
    ((hi_q & ~$past(en[NPH-1:0])) | (lo_q & ~$past(en[2*NPH-1:NPH]))) == '0);

endmodule

// File: tb/pwm3_gen_bench.sv
module pwm3_gen_bench;
  import pwm3_pkg::*;

  localparam int CW = 16;

  logic          clk = 1'b0, rst = 1'b1, wr_en = 1'b0, trip_n = 1'b1;
  logic [3:0]    wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [2:0]    pwm_hi, pwm_lo;
  logic          sync_irq, trip_irq;

  always #5 clk = ~clk;

  pwm3_gen u_pwm3_gen (
    .clk, .rst, .wr_en, .wr_addr, .wr_data, .trip_n,
    .pwm_hi, .pwm_lo, .sync_irq, .trip_irq
  );

  int checks = 0, fails = 0;

  // Configuration mirror used by the reference model.
  int cfg_per, cfg_dt, cfg_mpw, cfg_cd;
  bit [5:0] cfg_en;
  bit [2:0] cfg_xo;
  bit cfg_chh, cfg_chl, cfg_dbl;
  int duty[3], dup[3], ddn[3];

  // Scoreboard queues, one entry per period.
  bit    q_skip[$];
  string q_tag[$];
  int    q_len[$];
  int    q_cnt[$];

  task automatic push_skip();
    q_skip.push_back(1'b1); q_tag.push_back("-"); q_len.push_back(0);
    for (int i = 0; i < 6; i++) q_cnt.push_back(0);
  endtask

  task automatic push_zero(string tag);
    int p;
    p = (cfg_per == 0) ? 1 : cfg_per;
    q_skip.push_back(1'b0); q_tag.push_back(tag); q_len.push_back(2 * p);
    for (int i = 0; i < 6; i++) q_cnt.push_back(0);
  endtask

  task automatic push_model(string tag);
    int p, c, d, t, cnt[6];
    bit upk, car, h, l, tmp;
    p = (cfg_per == 0) ? 1 : cfg_per;
    for (int i = 0; i < 6; i++) cnt[i] = 0;
    for (int k = 0; k < 2 * p; k++) begin
      upk = (k < p);
      c   = upk ? k : 2 * p - 1 - k;
      car = ((k / (cfg_cd + 1)) % 2) == 0;
      for (int ph = 0; ph < 3; ph++) begin
        d = upk ? dup[ph] : ddn[ph];
        if (d > p) d = p;
        t = p - d;
        h = upk ? (c >= t + cfg_dt) : (c >= t);
        l = upk ? (c < t) : (c + cfg_dt < t);
        if (2 * d - cfg_dt < cfg_mpw) h = 1'b0;
        if (2 * t - cfg_dt < cfg_mpw) l = 1'b0;
        if (cfg_xo[ph]) begin tmp = h; h = l; l = tmp; end
        if (cfg_chh && !car) h = 1'b0;
        if (cfg_chl && !car) l = 1'b0;
        if (!cfg_en[ph])   h = 1'b0;
        if (!cfg_en[3+ph]) l = 1'b0;
        cnt[ph]   += int'(h);
        cnt[3+ph] += int'(l);
      end
    end
    q_skip.push_back(1'b0); q_tag.push_back(tag); q_len.push_back(2 * p);
    for (int i = 0; i < 6; i++) q_cnt.push_back(cnt[i]);
  endtask

  // Monitor: counts active cycles per pin between sync pulses.
  int m_len;
  int m_cnt[6];
  initial begin
    m_len = 0;
    for (int i = 0; i < 6; i++) m_cnt[i] = 0;
  end

  always @(negedge clk) begin : monitor
    bit    sk, bad;
    string tg;
    int    el, ec[6];
    if (sync_irq) begin
      if (q_len.size() > 0) begin
        sk = q_skip.pop_front(); tg = q_tag.pop_front(); el = q_len.pop_front();
        for (int i = 0; i < 6; i++) ec[i] = q_cnt.pop_front();
        if (!sk) begin
          bad = 1'b0;
          checks++;
          if (m_len != el) begin
            bad = 1'b1;
            $display("FAIL R1 period length (%s case): actual %0d expected %0d", tg, m_len, el);
          end
          for (int i = 0; i < 6; i++) begin
            if (m_cnt[i] != ec[i]) begin
              bad = 1'b1;
              $display("FAIL %s pin %0d active cycles: actual %0d expected %0d", tg, i, m_cnt[i], ec[i]);
            end
          end
          if (bad) fails++;
        end
      end
      m_len = 0;
      for (int i = 0; i < 6; i++) m_cnt[i] = 0;
    end
    m_len++;
    for (int i = 0; i < 3; i++) begin
      m_cnt[i]   += int'(pwm_hi[i]);
      m_cnt[3+i] += int'(pwm_lo[i]);
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp_v);
    end
  endtask

  task automatic wr(input logic [3:0] a, input int d);
    wr_en = 1'b1; wr_addr = a; wr_data = d[CW-1:0];
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic wait_sync();
    do @(negedge clk); while (!sync_irq);
    #1;
  endtask

  // Driver: reprogram at a period start, then predict following periods.
  task automatic apply(string tag, int nper);
    wait_sync();
    wr(A_PERIOD, cfg_per);
    wr(A_DEAD, cfg_dt);
    wr(A_MINPW, cfg_mpw);
    wr(A_DUTY_A, duty[0]);
    wr(A_DUTY_B, duty[1]);
    wr(A_DUTY_C, duty[2]);
    wr(A_OUTEN, int'(cfg_en));
    wr(A_SWAP, int'(cfg_xo));
    wr(A_CHOP, cfg_cd | (int'(cfg_chh) << 8) | (int'(cfg_chl) << 9));
    wr(A_MODE, int'(cfg_dbl));
    push_skip();
    for (int i = 0; i < 3; i++) begin dup[i] = duty[i]; ddn[i] = duty[i]; end
    repeat (nper) push_model(tag);
    repeat (nper + 1) wait_sync();
  endtask

  task automatic base_cfg();
    cfg_per = 20; cfg_dt = 0; cfg_mpw = 0; cfg_cd = 0;
    cfg_en = 6'h3f; cfg_xo = 3'b000; cfg_chh = 1'b0; cfg_chl = 1'b0; cfg_dbl = 1'b0;
    duty[0] = 10; duty[1] = 5; duty[2] = 15;
  endtask

  // Halves case: duty A changes right after a period start.
  task automatic halves(string tag, bit dbl_mode);
    base_cfg();
    cfg_dbl = dbl_mode; duty[0] = 6;
    apply(tag, 1);
    wr(A_DUTY_A, 14);
    dup[0] = 6; ddn[0] = dbl_mode ? 14 : 6;
    push_model(tag);
    dup[0] = 14; ddn[0] = 14; duty[0] = 14;
    push_model(tag);
    repeat (2) wait_sync();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : driver
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(pwm_hi == 3'b0, "R7 reset high pins", int'(pwm_hi), 0);
    chk(pwm_lo == 3'b0, "R7 reset low pins", int'(pwm_lo), 0);
    chk(trip_irq == 1'b0, "R10 reset fault flag", int'(trip_irq), 0);

    base_cfg();                                   apply("R2", 2);
    base_cfg(); cfg_dt = 3;                       apply("R3", 2);
    base_cfg(); cfg_dt = 2; cfg_mpw = 8;
    duty[0] = 3; duty[1] = 17; duty[2] = 10;      apply("R4", 2);
    base_cfg(); cfg_dt = 2;
    duty[0] = 30; duty[1] = 0; duty[2] = 20;      apply("R2", 2);
    base_cfg(); cfg_en = 6'b011_100;              apply("R7", 2);
    base_cfg(); cfg_dt = 1; cfg_xo = 3'b101;      apply("R8", 2);
    base_cfg(); cfg_cd = 2; cfg_chh = 1'b1;       apply("R9", 2);
    base_cfg(); cfg_chl = 1'b1; cfg_xo = 3'b010;  apply("R9", 2);

    halves("R5", 1'b0);
    halves("R6", 1'b1);

    // Trip shutdown and latch.
    base_cfg(); apply("R2", 1);
    trip_n = 1'b0;
    #1;
    chk(pwm_hi == 3'b0 && pwm_lo == 3'b0, "R10 outputs off at once",
        int'({pwm_hi, pwm_lo}), 0);
    push_skip();
    push_zero("R10");
    push_zero("R10");
    repeat (5) @(negedge clk);
    chk(trip_irq == 1'b1, "R10 fault flag set", int'(trip_irq), 1);
    #1 trip_n = 1'b1;
    repeat (3) wait_sync();
    chk(trip_irq == 1'b1, "R10 fault held after release", int'(trip_irq), 1);

    // Clear while tripped is ignored; clear after release works.
    push_skip();
    trip_n = 1'b0;
    repeat (4) @(negedge clk);
    #1 wr(A_TRIPCLR, 1);
    @(negedge clk);
    chk(trip_irq == 1'b1, "R11 clear ignored while trip low", int'(trip_irq), 1);
    #1 trip_n = 1'b1;
    repeat (4) @(negedge clk);
    #1 wr(A_TRIPCLR, 1);
    @(negedge clk);
    chk(trip_irq == 1'b0, "R11 clear after release", int'(trip_irq), 0);
    #1;
    for (int i = 0; i < 3; i++) begin dup[i] = duty[i]; ddn[i] = duty[i]; end
    push_model("R11");
    repeat (2) wait_sync();

    // Period changes, including the zero-period floor.
    base_cfg(); cfg_per = 7; cfg_dt = 1;          apply("R1", 2);
    base_cfg(); cfg_per = 0;
    duty[0] = 10; duty[1] = 0; duty[2] = 1;       apply("R1", 3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule